// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command interpreter of a serial flash device. It watches chip select, serial clock and one input data line, turns the bit stream into an instruction, an address and a data byte, and decides whether that instruction is obeyed. It works in both idle-low (mode 0) and idle-high (mode 3) clock polarity. Every pin is sampled by the block's own system clock through a short synchronizer, so the serial clock must run several times slower than the system clock.

The block owns the write-enable latch, the busy flag and the two-step software reset. Program, erase and status-write instructions are checked when chip select rises. If they pass, they leave as one-cycle strobes together with their 24-bit address or data byte. The busy flag then stays up for a parameterized number of system cycles, which stands in for the array operation. A status read shifts the busy/write-enable byte back out on the falling serial clock edge.

Top module: `spi_flash_cmd_frontend`

## Requirements
- R1: The first 8 bits after chip select falls form the instruction code. Bits are sampled on the rising serial clock edge, MSB first. For program and erase, the three following bytes form a 24-bit address, MSB first.
- R2: Both clock polarities work: clock idle low at the chip select edges (mode 0) and clock idle high (mode 3).
- R3: Instruction 05h puts the status byte on `miso_o`, bit 7 first, each bit changing on a falling serial clock edge, and repeats the byte for as long as clocks continue. Bit 0 is busy, bit 1 is write enable, and bits 7..2 read 0. `miso_oe_o` is high only while this read is active.
- R4: 06h sets the write-enable latch. 04h clears it.
- R5: Page program (02h, at least one data byte), erase and write status (01h, one data byte) act only when the latch is 1. When one acts, its strobe pulses and the latch clears. `busy_o` then stays high for T_PROG, T_ERASE/T_CHIP or T_WRSR cycles.
- R6: Every instruction other than a status read is dropped, with no state change, unless chip select rises after a whole number of 8-bit bytes.
- R7: A status read may be ended after any number of clocked bits without disturbing later instructions.
- R8: While busy, only 05h and suspend 75h are taken; all else is ignored. 75h pulses `susp_stb_o` only while busy.
- R9: 66h followed by 99h in the very next transaction starts a reset period of T_RESET cycles. During that period `sw_reset_o` is high, and the latch and busy flag are cleared.
- R10: Any other complete transaction between 66h and 99h disarms the reset.
- R11: During the reset period no instruction is accepted, including status reads.
- R12: Out of reset the latch and busy flag are 0. No instruction is accepted until chip select has been seen high at least once.
- R13: `erase_kind_o` encodes 20h as 0, 52h as 1, D8h as 2, and C7h/60h as 3. Chip erase needs only its opcode; the others need opcode plus 3 address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data into the block |
| miso_o | output | 1 | Serial data out of the block |
| miso_oe_o | output | 1 | Output enable for miso_o |
| wel_o | output | 1 | Write-enable latch |
| busy_o | output | 1 | Operation in progress |
| sw_reset_o | output | 1 | Software reset period active |
| prog_stb_o | output | 1 | Page program accepted (one cycle) |
| erase_stb_o | output | 1 | Erase accepted (one cycle) |
| erase_kind_o | output | 2 | Erase size code, valid with erase_stb_o |
| wrsr_stb_o | output | 1 | Write status accepted (one cycle) |
| susp_stb_o | output | 1 | Suspend accepted (one cycle) |
| addr_o | output | 24 | Address of the accepted program/erase |
| wrsr_data_o | output | 8 | First data byte of the accepted write status |

## Verification
Some rules are checked on every cycle by assertions: an executed strobe always finds the latch set and the block idle, and always leaves busy set and the latch clear. The latch can only rise while idle and outside a reset. A reset period only begins from an armed state. The output bit moves only after a falling clock or a chip select edge. Other behaviour only the directed scenarios can show: byte-boundary rejection, the address and erase code values, the exact busy and reset durations, the disarming transaction, and the power-up rule that chip select must first be seen high.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER32K = 8'h52;
  localparam logic [7:0] OP_ER64K = 8'hD8;
  localparam logic [7:0] OP_ERALL = 8'hC7;
  localparam logic [7:0] OP_ERALT = 8'h60;
  localparam logic [7:0] OP_SUSP  = 8'h75;
  localparam logic [7:0] OP_RSTEN = 8'h66;
  localparam logic [7:0] OP_RSTGO = 8'h99;

  typedef enum logic [3:0] {
    CK_NONE, CK_WREN, CK_WRDI, CK_RDSR, CK_WRSR,
    CK_PROG, CK_ERASE, CK_SUSP, CK_RSTEN, CK_RSTGO
  } cmd_kind_t;

  typedef enum logic [1:0] {
    EK_SECTOR = 2'd0, EK_HALF = 2'd1, EK_BLOCK = 2'd2, EK_CHIP = 2'd3
  } erase_kind_t;

  function automatic cmd_kind_t decode_op(input logic [7:0] op);
    case (op)
      OP_WREN:  return CK_WREN;
      OP_WRDI:  return CK_WRDI;
      OP_RDSR:  return CK_RDSR;
      OP_WRSR:  return CK_WRSR;
      OP_PROG:  return CK_PROG;
      OP_ER4K, OP_ER32K, OP_ER64K, OP_ERALL, OP_ERALT: return CK_ERASE;
      OP_SUSP:  return CK_SUSP;
      OP_RSTEN: return CK_RSTEN;
      OP_RSTGO: return CK_RSTGO;
      default:  return CK_NONE;
    endcase
  endfunction

  function automatic erase_kind_t erase_kind_of(input logic [7:0] op);
    case (op)
      OP_ER32K: return EK_HALF;
      OP_ER64K: return EK_BLOCK;
      OP_ERALL, OP_ERALT: return EK_CHIP;
      default:  return EK_SECTOR;
    endcase
  endfunction

  // Whole bytes (opcode included) a command needs before chip select rises.
  function automatic logic [2:0] min_bytes(input cmd_kind_t k, input erase_kind_t ek);
    case (k)
      CK_PROG:  return 3'd5;
      CK_ERASE: return (ek == EK_CHIP) ? 3'd1 : 3'd4;
      CK_WRSR:  return 3'd2;
      default:  return 3'd1;
    endcase
  endfunction

  function automatic logic busy_allowed(input cmd_kind_t k);
    return (k == CK_RDSR) || (k == CK_SUSP);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic [STAGES-1:0] cs_p, ck_p, d_p;
  logic cs_prev, ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p    <= '0;
      ck_p    <= '0;
      d_p     <= '0;
      cs_prev <= 1'b0;
      ck_prev <= 1'b0;
    end else begin
      cs_p    <= {cs_p[STAGES-2:0], cs_n_i};
      ck_p    <= {ck_p[STAGES-2:0], sclk_i};
      d_p     <= {d_p[STAGES-2:0], mosi_i};
      cs_prev <= cs_p[STAGES-1];
      ck_prev <= ck_p[STAGES-1];
    end
  end

  assign cs_n_s    = cs_p[STAGES-1];
  assign mosi_s    = d_p[STAGES-1];
  assign sclk_rise =  ck_p[STAGES-1] & ~ck_prev & ~cs_n_s;
  assign sclk_fall = ~ck_p[STAGES-1] &  ck_prev & ~cs_n_s;
  assign cs_fall   = ~cs_n_s &  cs_prev;
  assign cs_rise   =  cs_n_s & ~cs_prev;

endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             mosi_s,
  input  logic             rd_en,
  input  logic [7:0]       status,
  output logic             op_vld,
  output logic [7:0]       opcode,
  output logic [23:0]      addr,
  output logic [7:0]       wdat,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             bit_aligned,
  output logic             miso
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [7:0] sh, osh;
  logic [2:0] bit_cnt, ocnt;
  logic [7:0] next_byte;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign next_byte = {sh[6:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; osh <= '0; bit_cnt <= '0; ocnt <= '0;
      byte_cnt <= '0; opcode <= '0; addr <= '0; wdat <= '0;
      op_vld <= 1'b0; miso <= 1'b0;
    end else begin
      op_vld <= 1'b0;
      if (cs_fall) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ocnt     <= '0;
        miso     <= 1'b0;
      end else if (sclk_rise) begin
        sh      <= next_byte;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          byte_cnt <= sat_inc(byte_cnt);
          if (byte_cnt == '0) begin
            opcode <= next_byte;
            op_vld <= 1'b1;
          end
          if (byte_cnt >= CNT_W'(1) && byte_cnt <= CNT_W'(3))
            addr <= {addr[15:0], next_byte};
          if (byte_cnt == CNT_W'(1))
            wdat <= next_byte;
        end
      end else if (sclk_fall && rd_en) begin
        if (ocnt == '0) begin
          miso <= status[7];
          osh  <= {status[6:0], 1'b0};
        end else begin
          miso <= osh[7];
          osh  <= {osh[6:0], 1'b0};
        end
        ocnt <= ocnt + 1'b1;
      end
    end
  end

  assign bit_aligned = (bit_cnt == '0);

  // R3: the output bit only moves after a falling clock or a new transaction.
  p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sclk_fall || cs_fall));

  // R1: the opcode is reported only once a whole first byte is in.
  p_opcode_whole_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |-> (bit_cnt == '0) && (byte_cnt == CNT_W'(1)));

endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl import sfe_pkg::*; #(
  parameter int CNT_W   = 10,
  parameter int T_WRSR  = 64,
  parameter int T_PROG  = 256,
  parameter int T_ERASE = 1024,
  parameter int T_CHIP  = 4096,
  parameter int T_RESET = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             op_vld,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             bit_aligned,
  input  logic [23:0]      addr_in,
  input  logic [7:0]       wdat_in,
  output logic             wel_o,
  output logic             busy_o,
  output logic             resetting_o,
  output logic             rd_active_o,
  output logic             prog_stb_o,
  output logic             erase_stb_o,
  output erase_kind_t      erase_kind_o,
  output logic             wrsr_stb_o,
  output logic             susp_stb_o,
  output logic [23:0]      addr_o,
  output logic [7:0]       wdat_o
);
  localparam int T_MAX = max_of(max_of(max_of(T_WRSR, T_PROG), max_of(T_ERASE, T_CHIP)), T_RESET);
  localparam int DUR_W = $clog2(T_MAX + 1);

  logic primed_q, live_q, arm_q, wel_q, rd_q;
  cmd_kind_t   kind_q, kind_now;
  erase_kind_t ek_q;
  logic [DUR_W-1:0] busy_cnt, rst_cnt;
  logic busy, resetting, accept_now, long_enough, commit;
  logic ev_wren, ev_wrdi, ev_exec, ev_susp, ev_rsten, ev_rst;

  function automatic logic [DUR_W-1:0] dur_of(input cmd_kind_t k, input erase_kind_t ek);
    case (k)
      CK_WRSR:  return DUR_W'(T_WRSR);
      CK_PROG:  return DUR_W'(T_PROG);
      default:  return (ek == EK_CHIP) ? DUR_W'(T_CHIP) : DUR_W'(T_ERASE);
    endcase
  endfunction

  assign busy        = (busy_cnt != '0);
  assign resetting   = (rst_cnt != '0);
  assign kind_now    = decode_op(opcode);
  assign accept_now  = op_vld && live_q && !resetting && (!busy || busy_allowed(kind_now));
  assign long_enough = byte_cnt >= CNT_W'(min_bytes(kind_q, ek_q));
  assign commit      = cs_rise && live_q && bit_aligned && long_enough &&
                       (kind_q != CK_NONE) && (kind_q != CK_RDSR);

  assign ev_wren  = commit && (kind_q == CK_WREN);
  assign ev_wrdi  = commit && (kind_q == CK_WRDI);
  assign ev_exec  = commit && wel_q && (kind_q inside {CK_WRSR, CK_PROG, CK_ERASE});
  assign ev_susp  = commit && (kind_q == CK_SUSP) && busy;
  assign ev_rsten = commit && (kind_q == CK_RSTEN);
  assign ev_rst   = commit && (kind_q == CK_RSTGO) && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0; live_q <= 1'b0; arm_q <= 1'b0; wel_q <= 1'b0; rd_q <= 1'b0;
      kind_q <= CK_NONE; ek_q <= EK_SECTOR;
      busy_cnt <= '0; rst_cnt <= '0;
      prog_stb_o <= 1'b0; erase_stb_o <= 1'b0; wrsr_stb_o <= 1'b0; susp_stb_o <= 1'b0;
      erase_kind_o <= EK_SECTOR; addr_o <= '0; wdat_o <= '0;
    end else begin
      prog_stb_o  <= 1'b0;
      erase_stb_o <= 1'b0;
      wrsr_stb_o  <= 1'b0;
      susp_stb_o  <= ev_susp;

      if (cs_fall) begin
        live_q <= primed_q;
        kind_q <= CK_NONE;
        rd_q   <= 1'b0;
      end
      if (accept_now) begin
        kind_q <= kind_now;
        ek_q   <= erase_kind_of(opcode);
        rd_q   <= (kind_now == CK_RDSR);
      end
      if (cs_rise) begin
        live_q <= 1'b0;
        rd_q   <= 1'b0;
        if (live_q) arm_q <= ev_rsten;
      end

      if (ev_rst)                      primed_q <= 1'b0;
      else if (cs_n_s && !resetting)   primed_q <= 1'b1;

      if (ev_rst)        busy_cnt <= '0;
      else if (ev_exec)  busy_cnt <= dur_of(kind_q, ek_q);
      else if (busy)     busy_cnt <= busy_cnt - 1'b1;

      if (ev_rst)         rst_cnt <= DUR_W'(T_RESET);
      else if (resetting) rst_cnt <= rst_cnt - 1'b1;

      if (ev_rst || ev_exec || ev_wrdi) wel_q <= 1'b0;
      else if (ev_wren)                 wel_q <= 1'b1;

      if (ev_exec) begin
        prog_stb_o   <= (kind_q == CK_PROG);
        erase_stb_o  <= (kind_q == CK_ERASE);
        wrsr_stb_o   <= (kind_q == CK_WRSR);
        erase_kind_o <= ek_q;
        addr_o       <= addr_in;
        wdat_o       <= wdat_in;
      end
    end
  end

  assign wel_o       = wel_q;
  assign busy_o      = busy;
  assign resetting_o = resetting;
  assign rd_active_o = rd_q;

  // R5: an executed command needed the latch and an idle block.
  p_exec_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb_o || erase_stb_o || wrsr_stb_o) |-> $past(wel_q) && !$past(busy));

  // R5: an executed command leaves busy up and the latch down.
  p_exec_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb_o || erase_stb_o || wrsr_stb_o) |-> busy && !wel_q);

  // R8, R11: the latch only rises when idle and outside a reset period.
  p_wel_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> !$past(busy) && !$past(resetting));

  // R8: suspend is reported only during an operation.
  p_susp_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_stb_o |-> $past(busy));

  // R9: a reset period starts only from an armed state.
  p_reset_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetting) |-> $past(arm_q));

  // R11: nothing is accepted during the reset period.
  p_quiet_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> !(prog_stb_o || erase_stb_o || wrsr_stb_o || susp_stb_o) && !rd_q);

endmodule

// File: rtl/spi_flash_cmd_frontend.sv
module spi_flash_cmd_frontend import sfe_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10,
  parameter int T_WRSR      = 64,
  parameter int T_PROG      = 256,
  parameter int T_ERASE     = 1024,
  parameter int T_CHIP      = 4096,
  parameter int T_RESET     = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_i,
  input  logic        sclk_i,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  output logic        wel_o,
  output logic        busy_o,
  output logic        sw_reset_o,
  output logic        prog_stb_o,
  output logic        erase_stb_o,
  output logic [1:0]  erase_kind_o,
  output logic        wrsr_stb_o,
  output logic        susp_stb_o,
  output logic [23:0] addr_o,
  output logic [7:0]  wrsr_data_o
);
  logic cs_n_s, mosi_s, sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic op_vld, bit_aligned, rd_active, wel, busy;
  logic [7:0] opcode, wdat;
  logic [23:0] addr;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0] status;
  erase_kind_t ek;

  assign status = {6'b0, wel, busy};

  sfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  sfe_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .rd_en(rd_active), .status(status),
    .op_vld(op_vld), .opcode(opcode), .addr(addr), .wdat(wdat),
    .byte_cnt(byte_cnt), .bit_aligned(bit_aligned), .miso(miso_o)
  );

  sfe_ctrl #(
    .CNT_W(CNT_W), .T_WRSR(T_WRSR), .T_PROG(T_PROG), .T_ERASE(T_ERASE),
    .T_CHIP(T_CHIP), .T_RESET(T_RESET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .op_vld(op_vld), .opcode(opcode), .byte_cnt(byte_cnt), .bit_aligned(bit_aligned),
    .addr_in(addr), .wdat_in(wdat), .wel_o(wel), .busy_o(busy),
    .resetting_o(sw_reset_o), .rd_active_o(rd_active), .prog_stb_o(prog_stb_o),
    .erase_stb_o(erase_stb_o), .erase_kind_o(ek), .wrsr_stb_o(wrsr_stb_o),
    .susp_stb_o(susp_stb_o), .addr_o(addr_o), .wdat_o(wrsr_data_o)
  );

  assign erase_kind_o = ek;
  assign miso_oe_o    = rd_active;
  assign wel_o        = wel;
  assign busy_o       = busy;

endmodule

// File: tb/spi_flash_cmd_frontend_test.sv
module spi_flash_cmd_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int TW         = 30;
  localparam int TP         = 40;
  localparam int TE         = 1500;
  localparam int TC         = 600;
  localparam int TR         = 800;
  localparam int WD         = 150000;

  logic clk = 0, rst_n = 0, cs_n_i = 0, sclk_i = 0, mosi_i = 0;
  logic miso_o, miso_oe_o, wel_o, busy_o, sw_reset_o;
  logic prog_stb_o, erase_stb_o, wrsr_stb_o, susp_stb_o;
  logic [1:0] erase_kind_o;
  logic [23:0] addr_o;
  logic [7:0] wrsr_data_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_prog = 0, n_er = 0, n_wrsr = 0, n_susp = 0, n_oe = 0;
  int brun = 0, rrun = 0, last_busy = 0, last_rst = 0;
  logic [1:0] last_ek = 0;
  logic [23:0] last_addr = 0;
  logic [7:0] last_wd = 0;
  logic [63:0] rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_cmd_frontend #(.T_WRSR(TW), .T_PROG(TP), .T_ERASE(TE), .T_CHIP(TC), .T_RESET(TR)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .wel_o(wel_o), .busy_o(busy_o),
    .sw_reset_o(sw_reset_o), .prog_stb_o(prog_stb_o), .erase_stb_o(erase_stb_o),
    .erase_kind_o(erase_kind_o), .wrsr_stb_o(wrsr_stb_o), .susp_stb_o(susp_stb_o),
    .addr_o(addr_o), .wrsr_data_o(wrsr_data_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (prog_stb_o) begin n_prog <= n_prog + 1; last_addr <= addr_o; end
      if (erase_stb_o) begin n_er <= n_er + 1; last_addr <= addr_o; last_ek <= erase_kind_o; end
      if (wrsr_stb_o) begin n_wrsr <= n_wrsr + 1; last_wd <= wrsr_data_o; end
      if (susp_stb_o) n_susp <= n_susp + 1;
      if (miso_oe_o) n_oe <= n_oe + 1;
      if (busy_o) brun <= brun + 1;
      else if (brun != 0) begin last_busy <= brun; brun <= 0; end
      if (sw_reset_o) rrun <= rrun + 1;
      else if (rrun != 0) begin last_rst <= rrun; rrun <= 0; end
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) if (cyc == WD) begin
    n_chk = n_chk + 1; n_fail = n_fail + 1;
    $display("FAIL watchdog (all requirements): got %0d cycles expected fewer", cyc);
    report();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] d, input int nbits, input bit m3);
    rx = '0;
    sclk_i = m3;
    repeat (4) @(negedge clk);
    cs_n_i = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (m3) sclk_i = 0;
      mosi_i = d[63-i];
      repeat (H) @(negedge clk);
      rx[63-i] = miso_o;
      sclk_i = 1;
      repeat (H) @(negedge clk);
      if (!m3) sclk_i = 0;
    end
    repeat (H) @(negedge clk);
    cs_n_i = 1;
    repeat (16) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    xfer({op, 56'h0}, 8, 0);
  endtask

  task automatic wait_idle;
    while (busy_o || sw_reset_o) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_powerup;
    chk("R12 reset wel", wel_o, 0);
    chk("R12 reset busy", busy_o, 0);
    chk("R12 reset oe", miso_oe_o, 0);
    chk("R12 reset sw_reset", sw_reset_o, 0);
    // cs held low since power-up: clock 06h without a prior high level
    for (int i = 0; i < 8; i++) begin
      mosi_i = 8'h06 >> (7 - i);
      repeat (H) @(negedge clk); sclk_i = 1;
      repeat (H) @(negedge clk); sclk_i = 0;
    end
    repeat (H) @(negedge clk);
    cs_n_i = 1;
    repeat (16) @(negedge clk);
    chk("R12 first instruction ignored", wel_o, 0);
    op1(8'h06);
    chk("R4 write enable sets latch", wel_o, 1);
  endtask

  task automatic t_status;
    xfer({8'h05, 56'h0}, 24, 0);
    chk("R3 status byte mode0", rx[55:48], 8'h02);
    chk("R3 status repeats", rx[47:40], 8'h02);
    xfer({8'h05, 56'h0}, 16, 1);
    chk("R2 status byte mode3", rx[55:48], 8'h02);
    chk("R3 oe low after read", miso_oe_o, 0);
    xfer({8'h04, 56'h0}, 8, 1);
    chk("R4 write disable mode3 (R2)", wel_o, 0);
  endtask

  task automatic t_prog;
    int p0 = n_prog;
    xfer({8'h02, 24'h123456, 8'hAA, 24'h0}, 40, 0);
    chk("R5 program without latch dropped", n_prog, p0);
    op1(8'h06);
    xfer({8'h02, 24'h123456, 8'hAA, 24'h0}, 40, 0);
    chk("R5 program strobe", n_prog, p0 + 1);
    chk("R1 address MSB first", last_addr, 24'h123456);
    chk("R5 latch cleared", wel_o, 0);
    chk("R5 busy raised", busy_o, 1);
    wait_idle();
    chk("R5 program duration", last_busy, TP);
  endtask

  task automatic t_misaligned;
    int e0 = n_er;
    op1(8'h06);
    xfer({8'h20, 24'h0ABCDE, 32'h0}, 35, 0);
    chk("R6 unaligned erase dropped", n_er, e0);
    chk("R6 latch kept", wel_o, 1);
    chk("R6 not busy", busy_o, 0);
    xfer({8'h20, 24'hABCDEF, 32'h0}, 32, 1);
    chk("R13 sector erase strobe", n_er, e0 + 1);
    chk("R13 sector kind 0", last_ek, 0);
    chk("R1 erase address", last_addr, 24'hABCDEF);
    wait_idle();
  endtask

  task automatic t_erase_kinds;
    op1(8'h06);
    xfer({8'hD8, 24'h010000, 32'h0}, 32, 0);
    chk("R13 64k kind 2", last_ek, 2);
    wait_idle();
    op1(8'h06);
    op1(8'hC7);
    chk("R13 chip kind 3", last_ek, 3);
    wait_idle();
    chk("R5 chip erase duration", last_busy, TC);
  endtask

  task automatic t_busy_gate;
    int s0;
    op1(8'h06);
    xfer({8'h52, 24'h020000, 32'h0}, 32, 0);
    chk("R13 32k kind 1", last_ek, 1);
    op1(8'h06);
    chk("R8 write enable ignored while busy", wel_o, 0);
    xfer({8'h05, 56'h0}, 16, 0);
    chk("R8 status read while busy", rx[55:48], 8'h01);
    s0 = n_susp;
    op1(8'h75);
    chk("R8 suspend while busy", n_susp, s0 + 1);
    wait_idle();
    op1(8'h75);
    chk("R8 suspend when idle ignored", n_susp, s0 + 1);
  endtask

  task automatic t_partial_read;
    xfer({8'h05, 56'h0}, 13, 1);
    op1(8'h06);
    chk("R7 after cut-short read", wel_o, 1);
  endtask

  task automatic t_reset;
    int o0;
    op1(8'h66);
    op1(8'h99);
    chk("R9 reset period active", sw_reset_o, 1);
    chk("R9 latch cleared", wel_o, 0);
    op1(8'h06);
    chk("R11 write enable refused", wel_o, 0);
    o0 = n_oe;
    xfer({8'h05, 56'h0}, 16, 0);
    chk("R11 status read refused", n_oe, o0);
    wait_idle();
    chk("R9 reset duration", last_rst, TR);
    op1(8'h06);
    chk("R9 accepts after reset", wel_o, 1);
  endtask

  task automatic t_disarm;
    op1(8'h66);
    xfer({8'h05, 56'h0}, 16, 0);
    op1(8'h99);
    chk("R10 reset disarmed", sw_reset_o, 0);
    chk("R10 latch untouched", wel_o, 1);
  endtask

  task automatic t_wrsr;
    int w0 = n_wrsr;
    xfer({8'h01, 8'h5A, 48'h0}, 16, 0);
    chk("R5 write status strobe", n_wrsr, w0 + 1);
    chk("R5 write status data", last_wd, 8'h5A);
    wait_idle();
    chk("R5 write status duration", last_busy, TW);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_powerup();
    t_status();
    t_prog();
    t_misaligned();
    t_erase_kinds();
    t_busy_gate();
    t_partial_read();
    t_reset();
    t_disarm();
    t_wrsr();
    report();
    $finish;
  end

endmodule